// File: doc/BRIEF.md
# Two-Slot Issue Hazard Controller

This block sits at the issue stage of a statically scheduled, in-order pipeline that accepts one two-instruction packet per cycle. Packets are aligned to 8 bytes. Slot 0 always carries an ALU or branch operation, and slot 1 always carries a load or store. Each slot arrives already decoded: a valid bit, a kind bit, two source register numbers, a destination register number and a write enable. A slot with its valid bit low is a nop.

Each cycle the block chooses one of three actions for the packet it is shown:

- issue both slots;
- issue the ALU half now and hold the memory half for the next cycle, because the memory slot reads a result produced by the ALU slot of the same packet and no path exists to pass that result across;
- hold the whole packet for one cycle, because a load issued in the previous cycle writes a register that the packet reads.

While the block holds a packet it raises `stall`, and the upstream fetch and decode stages keep presenting the same packet. The block also keeps a packet address that steps by 8 each time a packet completes. It counts issued instructions, so the issue rate of a known schedule can be measured.

Top module: `dual_issue_ctl`

## Requirements
- R1: A synchronous active-low reset sets `split_pending` to 0, `pkt_addr` to 0 and `issued_cnt` to 0. It also discards any load recorded before the reset, so the first packet after reset never stalls on that load.
- R2: When neither hazard applies, every valid slot issues in the same cycle and `stall` is 0.
- R3: A slot whose valid bit is 0 never asserts its issue output. It never causes a split or a stall, whatever its other fields hold.
- R4: A split happens when the ALU slot is valid, has `alu_kind`=0 (ALU operation), has `alu_we`=1 and has a nonzero destination, and the valid memory slot names that register in either source field. On the first cycle the block asserts `issue_alu`=1, `issue_mem`=0 and `stall`=1. On the next cycle it asserts `issue_alu`=0, `issue_mem`=1, `stall`=0 and `split_pending`=1.
- R5: A load-use stall happens when the previous cycle issued a load (`mem_kind`=0, `mem_we`=1, nonzero destination) and any source field of any valid slot equals that destination. The cycle then issues nothing and asserts `stall`=1. The held packet issues on the next cycle, and a load-use stall never repeats back to back.
- R6: Register 0 is never a dependency, either inside a packet or across a load.
- R7: A store (`mem_kind`=1) and a branch (`alu_kind`=1) never produce a destination dependency, even when their write enable is set.
- R8: `pkt_addr` grows by 8 after every cycle with `stall`=0 and keeps its value after every cycle with `stall`=1.
- R9: `issued_cnt` grows by the number of instructions issued in each cycle. Under the four-cycle loop schedule, five instructions issue in four cycles.
- R10: When a packet has both a load-use hazard and an internal dependency, it first stalls as a whole for one cycle and then splits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alu_vld | input | 1 | ALU slot holds a real instruction |
| alu_kind | input | 1 | 0 = ALU operation, 1 = branch |
| alu_we | input | 1 | ALU slot writes its destination |
| alu_src_a | input | REG_W | ALU slot first source register |
| alu_src_b | input | REG_W | ALU slot second source register |
| alu_dst | input | REG_W | ALU slot destination register |
| mem_vld | input | 1 | Memory slot holds a real instruction |
| mem_kind | input | 1 | 0 = load, 1 = store |
| mem_we | input | 1 | Memory slot writes its destination |
| mem_src_a | input | REG_W | Memory slot base register |
| mem_src_b | input | REG_W | Memory slot store-data register |
| mem_dst | input | REG_W | Memory slot destination register |
| issue_alu | output | 1 | ALU slot goes to execute this cycle |
| issue_mem | output | 1 | Memory slot goes to execute this cycle |
| stall | output | 1 | Hold fetch/decode; the packet is not finished |
| split_pending | output | 1 | This cycle issues the second half of a split packet |
| pkt_addr | output | ADDR_W | Address of the current packet |
| issued_cnt | output | CNT_W | Number of instructions issued since reset |

## Verification
The assertions rely on the upstream stages obeying `stall`. When `stall` is high, the same packet must appear again on the next cycle; otherwise the split's second half would issue the memory slot of a different packet. The scoreboard driver keeps to this by presenting every held packet again, unchanged, for as many cycles as the requirements say it will be held. Source fields that a slot does not use are driven to register 0, so they cannot create dependencies the stimulus did not intend.

// File: rtl/dual_issue_pkg.sv
// Shared encodings for the two-slot issue controller.
// Assumes one kind bit per slot, as decoded upstream.
package dual_issue_pkg;
    typedef enum logic {
        ALU_OP     = 1'b0,
        ALU_BRANCH = 1'b1
    } alu_kind_e;

    typedef enum logic {
        MEM_LOAD  = 1'b0,
        MEM_STORE = 1'b1
    } mem_kind_e;
endpackage

// File: rtl/pkt_dep_detect.sv
// Detects a dependency inside one packet: the memory slot reads a register
// that the ALU slot of the same packet writes. Branches and register 0
// never count. Assumes nop slots are marked only by their valid bit.
module pkt_dep_detect
    import dual_issue_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             alu_vld,
    input  logic             alu_kind,
    input  logic             alu_we,
    input  logic [REG_W-1:0] alu_dst,
    input  logic             mem_vld,
    input  logic [REG_W-1:0] mem_src_a,
    input  logic [REG_W-1:0] mem_src_b,
    output logic             split_need
);
    logic alu_writes;

    // Decide whether the ALU slot really produces a register result.
    always_comb begin
        alu_writes = alu_vld && (alu_kind == ALU_OP) && alu_we && (alu_dst != '0);
    end

    // Compare that result against both memory-slot sources.
    always_comb begin
        split_need = alu_writes && mem_vld &&
                     ((mem_src_a == alu_dst) || (mem_src_b == alu_dst));
    end
endmodule

// File: rtl/ld_use_detect.sv
// Compares the destination of the previous cycle's load with every source
// field of the current packet. Register 0 never matches. Assumes the
// caller has already cleared ld_vld for stores and zero destinations.
module ld_use_detect #(
    parameter int REG_W = 5,
    parameter int NSRC  = 4
) (
    input  logic                  ld_vld,
    input  logic [REG_W-1:0]      ld_dst,
    input  logic [NSRC*REG_W-1:0] srcs,
    input  logic [NSRC-1:0]       src_vld,
    output logic                  lu_hazard
);
    logic [NSRC-1:0] hit;

    for (genvar i = 0; i < NSRC; i++) begin : g_cmp
        // Match one source field against the tracked load destination.
        always_comb begin
            hit[i] = src_vld[i] && (srcs[i*REG_W +: REG_W] == ld_dst) &&
                     (ld_dst != '0);
        end
    end

    // Raise the hazard when a tracked load meets any match.
    always_comb begin
        lu_hazard = ld_vld && (|hit);
    end
endmodule

// File: rtl/dual_issue_ctl.sv
// Issue-stage control for an in-order pipeline fed with two-slot packets
// (slot 0 ALU/branch, slot 1 load/store). It splits packets that carry an
// internal dependency, stalls for one cycle on load-use, steps the packet
// address and counts issued instructions. It assumes the upstream stages
// present the same packet again while stall is high.
module dual_issue_ctl
    import dual_issue_pkg::*;
#(
    parameter int REG_W     = 5,
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 16,
    parameter int PKT_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_vld,
    input  logic              alu_kind,
    input  logic              alu_we,
    input  logic [REG_W-1:0]  alu_src_a,
    input  logic [REG_W-1:0]  alu_src_b,
    input  logic [REG_W-1:0]  alu_dst,
    input  logic              mem_vld,
    input  logic              mem_kind,
    input  logic              mem_we,
    input  logic [REG_W-1:0]  mem_src_a,
    input  logic [REG_W-1:0]  mem_src_b,
    input  logic [REG_W-1:0]  mem_dst,
    output logic              issue_alu,
    output logic              issue_mem,
    output logic              stall,
    output logic              split_pending,
    output logic [ADDR_W-1:0] pkt_addr,
    output logic [CNT_W-1:0]  issued_cnt
);
    localparam int NSRC = 4;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PKT_BYTES);

    logic             pend_q;
    logic             ld_vld_q;
    logic [REG_W-1:0] ld_dst_q;
    logic             split_need;
    logic             lu_hazard;
    logic             load_issued;

    pkt_dep_detect #(.REG_W(REG_W)) u_dep (
        .alu_vld    (alu_vld),
        .alu_kind   (alu_kind),
        .alu_we     (alu_we),
        .alu_dst    (alu_dst),
        .mem_vld    (mem_vld),
        .mem_src_a  (mem_src_a),
        .mem_src_b  (mem_src_b),
        .split_need (split_need)
    );

    ld_use_detect #(.REG_W(REG_W), .NSRC(NSRC)) u_lu (
        .ld_vld    (ld_vld_q),
        .ld_dst    (ld_dst_q),
        .srcs      ({mem_src_b, mem_src_a, alu_src_b, alu_src_a}),
        .src_vld   ({mem_vld, mem_vld, alu_vld, alu_vld}),
        .lu_hazard (lu_hazard)
    );

    // Choose the issue action: finish a split, stall for load-use,
    // start a split, or issue the whole packet.
    always_comb begin
        issue_alu = 1'b0;
        issue_mem = 1'b0;
        stall     = 1'b0;
        if (pend_q) begin
            issue_mem = mem_vld;
        end else if (lu_hazard) begin
            stall = 1'b1;
        end else if (split_need) begin
            issue_alu = 1'b1;
            stall     = 1'b1;
        end else begin
            issue_alu = alu_vld;
            issue_mem = mem_vld;
        end
    end

    // Note whether this cycle sends a register-writing load to execute.
    always_comb begin
        load_issued = issue_mem && (mem_kind == MEM_LOAD) && mem_we && (mem_dst != '0);
    end

    // Hold the split flag and the destination of the last issued load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            ld_vld_q <= 1'b0;
            ld_dst_q <= '0;
        end else begin
            pend_q   <= !pend_q && !lu_hazard && split_need;
            ld_vld_q <= load_issued;
            ld_dst_q <= mem_dst;
        end
    end

    // Step the packet address when a packet completes; count issued work.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_addr   <= '0;
            issued_cnt <= '0;
        end else begin
            if (!stall) pkt_addr <= pkt_addr + STEP;
            issued_cnt <= issued_cnt + CNT_W'(issue_alu) + CNT_W'(issue_mem);
        end
    end

    assign split_pending = pend_q;

    // R4
    split_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        split_pending |-> (!issue_alu && !stall));

    // R4
    split_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && issue_alu && !issue_mem && stall) |=> split_pending);

    // R5
    lu_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && stall && !issue_alu) |=> !(stall && !issue_alu));

    // R8
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !stall) |=> (pkt_addr == $past(pkt_addr) + STEP));

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && stall) |=> $stable(pkt_addr));

    // R3
    nop_alu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alu_vld |-> !issue_alu);

    // R3
    nop_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_vld |-> !issue_mem);
endmodule

// File: tb/dual_issue_ctl_tb_top.sv
// Scoreboard bench: the driver applies one packet per cycle and queues the
// outputs the requirements predict; the monitor pops and compares them.
module dual_issue_ctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int REG_W  = 5;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;

    localparam logic K_ALU = 1'b0, K_BR = 1'b1, K_LD = 1'b0, K_ST = 1'b1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alu_vld, alu_kind, alu_we, mem_vld, mem_kind, mem_we;
    logic [REG_W-1:0] alu_src_a, alu_src_b, alu_dst, mem_src_a, mem_src_b, mem_dst;
    logic issue_alu, issue_mem, stall, split_pending;
    logic [ADDR_W-1:0] pkt_addr;
    logic [CNT_W-1:0] issued_cnt;

    int total = 0;
    int bad   = 0;
    logic [ADDR_W-1:0] exp_addr = '0;
    logic [CNT_W-1:0]  exp_cnt  = '0;

    typedef struct {
        logic ia, im, st, sp;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        string tag;
    } exp_t;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_issue_ctl #(.REG_W(REG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .alu_vld(alu_vld), .alu_kind(alu_kind), .alu_we(alu_we),
        .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_dst(alu_dst),
        .mem_vld(mem_vld), .mem_kind(mem_kind), .mem_we(mem_we),
        .mem_src_a(mem_src_a), .mem_src_b(mem_src_b), .mem_dst(mem_dst),
        .issue_alu(issue_alu), .issue_mem(issue_mem), .stall(stall),
        .split_pending(split_pending), .pkt_addr(pkt_addr), .issued_cnt(issued_cnt)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Driver: apply a packet now, queue the prediction, wait one cycle.
    task automatic pkt(input logic av, ak, aw, input logic [REG_W-1:0] a1, a2, ad,
                       input logic mv, mk, mw, input logic [REG_W-1:0] m1, m2, md,
                       input logic e_ia, e_im, e_st, e_sp, input string tag);
        exp_t e;
        alu_vld = av; alu_kind = ak; alu_we = aw;
        alu_src_a = a1; alu_src_b = a2; alu_dst = ad;
        mem_vld = mv; mem_kind = mk; mem_we = mw;
        mem_src_a = m1; mem_src_b = m2; mem_dst = md;
        e.ia = e_ia; e.im = e_im; e.st = e_st; e.sp = e_sp;
        e.addr = exp_addr; e.cnt = exp_cnt; e.tag = tag;
        q.push_back(e);
        if (!e_st) exp_addr = exp_addr + 32'd8;
        exp_cnt = exp_cnt + CNT_W'(e_ia) + CNT_W'(e_im);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        alu_vld = 1'b0; mem_vld = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_addr = '0;
        exp_cnt  = '0;
    endtask

    // Monitor: compare each queued prediction just after the inputs settle.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk({e.tag, " issue_alu"}, 32'(issue_alu), 32'(e.ia));
                chk({e.tag, " issue_mem"}, 32'(issue_mem), 32'(e.im));
                chk({e.tag, " stall"}, 32'(stall), 32'(e.st));
                chk({e.tag, " split_pending"}, 32'(split_pending), 32'(e.sp));
                chk({e.tag, " pkt_addr R8"}, pkt_addr, e.addr);
                chk({e.tag, " issued_cnt R9"}, 32'(issued_cnt), 32'(e.cnt));
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        alu_vld = 0; alu_kind = 0; alu_we = 0; alu_src_a = 0; alu_src_b = 0; alu_dst = 0;
        mem_vld = 0; mem_kind = 0; mem_we = 0; mem_src_a = 0; mem_src_b = 0; mem_dst = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_addr = '0; exp_cnt = '0;
        // R1 reset state
        pkt(0,K_ALU,0,0,0,0, 0,K_LD,0,0,0,0, 0,0,0,0, "R1 reset");
        // R1 a load recorded before reset is forgotten
        pkt(0,K_ALU,0,0,0,0, 1,K_LD,1,1,0,5, 0,1,0,0, "R1 pre-load");
        do_reset();
        pkt(1,K_ALU,1,5,0,6, 0,K_LD,0,0,0,0, 1,0,0,0, "R1 load cleared");
        // R2 independent pair
        pkt(1,K_ALU,1,2,3,1, 1,K_LD,1,5,0,4, 1,1,0,0, "R2 pair");
        // R5 load-use on ALU source, then release
        pkt(1,K_ALU,1,4,2,3, 0,K_LD,0,0,0,0, 0,0,1,0, "R5 stall");
        pkt(1,K_ALU,1,4,2,3, 0,K_LD,0,0,0,0, 1,0,0,0, "R5 release");
        // R4 split
        pkt(1,K_ALU,1,2,3,6, 1,K_ST,0,1,6,0, 1,0,1,0, "R4 first half");
        pkt(1,K_ALU,1,2,3,6, 1,K_ST,0,1,6,0, 0,1,0,1, "R4 second half");
        // R3 nop ALU slot with live-looking fields
        pkt(0,K_ALU,1,0,0,7, 1,K_LD,1,7,0,9, 0,1,0,0, "R3 alu nop");
        // R3 nop memory slot holding load fields is not tracked
        pkt(1,K_ALU,1,2,0,3, 0,K_LD,1,0,0,12, 1,0,0,0, "R3 mem nop");
        pkt(1,K_ALU,1,12,0,3, 1,K_ST,0,12,12,0, 1,1,0,0, "R3 mem nop no stall");
        // R6 register 0 inside a packet and across a load
        pkt(1,K_ALU,1,2,0,0, 1,K_LD,1,0,0,0, 1,1,0,0, "R6 r0 packet");
        pkt(1,K_ALU,1,0,0,2, 1,K_ST,0,0,0,0, 1,1,0,0, "R6 r0 load");
        // R7 store with write enable, branch with write enable
        pkt(0,K_ALU,0,0,0,0, 1,K_ST,1,1,2,10, 0,1,0,0, "R7 store");
        pkt(1,K_BR,1,10,0,11, 1,K_ST,0,11,10,0, 1,1,0,0, "R7 branch");
        // R10 load-use then split on the same packet
        pkt(0,K_ALU,0,0,0,0, 1,K_LD,1,1,0,12, 0,1,0,0, "R10 load");
        pkt(1,K_ALU,1,12,0,13, 1,K_ST,0,1,13,0, 0,0,1,0, "R10 stall");
        pkt(1,K_ALU,1,12,0,13, 1,K_ST,0,1,13,0, 1,0,1,0, "R10 split");
        pkt(1,K_ALU,1,12,0,13, 1,K_ST,0,1,13,0, 0,1,0,1, "R10 tail");
        // R5 load-use through store-data source
        pkt(0,K_ALU,0,0,0,0, 1,K_LD,1,1,0,14, 0,1,0,0, "R5 load b");
        pkt(0,K_ALU,0,0,0,0, 1,K_ST,0,2,14,0, 0,0,1,0, "R5 store data stall");
        pkt(0,K_ALU,0,0,0,0, 1,K_ST,0,2,14,0, 0,1,0,0, "R5 store data go");
        // R9 loop: 5 instructions in 4 cycles
        do_reset();
        pkt(0,K_ALU,0,0,0,0, 1,K_LD,1,17,0,8, 0,1,0,0, "R9 loop c1");
        pkt(1,K_ALU,1,17,0,17, 0,K_LD,0,0,0,0, 1,0,0,0, "R9 loop c2");
        pkt(1,K_ALU,1,8,18,8, 0,K_LD,0,0,0,0, 1,0,0,0, "R9 loop c3");
        pkt(1,K_BR,0,17,0,0, 1,K_ST,0,17,8,0, 1,1,0,0, "R9 loop c4");
        pkt(0,K_ALU,0,0,0,0, 0,K_LD,0,0,0,0, 0,0,0,0, "R9 loop end");
        #2;
        chk("R9 count after loop", 32'(issued_cnt), 32'd5);
        chk("R8 addr after loop", pkt_addr, 32'd40);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule